// File: doc/BRIEF.md
# Interrupt Ring Reader with Overflow Recovery

This block drains an interrupt vector ring from the consumer side. A producer elsewhere writes 16-byte vectors into a ring in memory and advances a byte-addressed write pointer. The reader compares that pointer with its own read pointer. For every pending vector it issues four 32-bit word reads through a simple memory read port and decodes the vector into its source id, source data, ring id, VMID and PASID fields. It offers each decoded vector on a valid/ready output and advances its read pointer once the vector is accepted.

If the write pointer arrives with its overflow flag set, the producer has lapped the reader. The reader then abandons its position, moves to the oldest vector that is still intact (one slot past the write pointer) and raises a one-cycle request to clear the flag. When the ring is drained it copies its read pointer to a published output, which the producer uses to learn which slots are free again. It then looks at the write pointer again before going idle. Dropping `enable` puts the reader back to slot zero.

Top module: `irq_ring_reader`

## Requirements
- R1: Pointers count bytes. A vector starting at read pointer P is fetched as four read requests on consecutive cycles, to word addresses P>>2, P>>2+1, P>>2+2 and P>>2+3. Each word is returned on `mem_rdata` in the cycle after its request.
- R2: `ev_src_id` is bits [7:0] of the first word. `ev_src_data` is bits [27:0] of the second word.
- R3: `ev_ring_id`, `ev_vmid` and `ev_pasid` are bits [7:0], [15:8] and [31:16] of the third word. The fourth word is read but has no effect on any output.
- R4: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and every field stays stable.
- R5: Each accepted vector advances the read pointer by 16 modulo 2**PTR_W. The next fetch starts at the advanced address.
- R6: Bit 0 of `wptr_in` is the overflow flag. If the reader is idle and sees the flag with no clear request outstanding, it sets its read pointer to (effective write pointer + 16) modulo 2**PTR_W and drives `ovf_clr` high for exactly one cycle. The flag is ignored during the cycle in which `ovf_clr` is high.
- R7: The effective write pointer is `wptr_in` with bit 0 forced to zero. Vectors are pending whenever this value differs from the read pointer.
- R8: Vectors are fetched and offered back to back until the advanced read pointer equals the effective write pointer. `rptr_out` takes that value two cycles after the last acceptance and otherwise holds.
- R9: After publishing, the reader re-examines the write pointer and processes newly arrived vectors without outside action.
- R10: While `enable` is low, the reader returns to idle: one cycle later both the internal read pointer and `rptr_out` are zero, and `ev_valid`, `mem_req` and `ovf_clr` are low.
- R11: After reset, `rptr_out` is zero and `ev_valid`, `mem_req` and `ovf_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Reader enable; low returns the reader to slot zero |
| wptr_in | input | PTR_W | Producer byte write pointer; bit 0 is the overflow flag |
| rptr_out | output | PTR_W | Published read pointer |
| ovf_clr | output | 1 | One-cycle request to clear the overflow flag |
| mem_req | output | 1 | Word read request |
| mem_addr | output | PTR_W-2 | Word address of the read |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| ev_valid | output | 1 | Decoded vector available |
| ev_ready | input | 1 | Consumer accepts the vector |
| ev_src_id | output | 8 | Interrupt source id |
| ev_src_data | output | 28 | Interrupt source data |
| ev_ring_id | output | 8 | Originating ring id |
| ev_vmid | output | 8 | Virtual machine id |
| ev_pasid | output | 16 | Process address space id |

## Verification
The bench builds the reader with PTR_W = 8, which gives a ring of only sixteen vectors. Because the ring is so small, pointer wrap, a full lap after an overflow jump and re-entry after publishing all occur within a few hundred cycles. A behavioural model steps alongside the design and checks fetch addresses, decoded fields, the clear pulse and the published pointer on every clock. The ring memory holds random data, so the ignored fourth word changes from slot to slot.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 4;
  localparam int ENTRY_BYTES = ENTRY_WORDS * (WORD_W / 8);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_EMIT    = 2'd2,
    ST_PUBLISH = 2'd3
  } rr_state_e;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } iv_entry_t;

endpackage

// File: rtl/irq_rr_wptr.sv
module irq_rr_wptr #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] wptr_in,
  input  logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wptr_eff,
  output logic             ovf_flag,
  output logic [PTR_W-1:0] jump_ptr,
  output logic             pending
);
  import irq_rr_pkg::*;

  localparam logic [PTR_W-1:0] STEP = PTR_W'(ENTRY_BYTES);

  always_comb begin
    ovf_flag = wptr_in[0];
    wptr_eff = {wptr_in[PTR_W-1:1], 1'b0};
    jump_ptr = wptr_eff + STEP;
    pending  = (wptr_eff != rptr);
  end

endmodule

// File: rtl/irq_rr_fetch.sv
module irq_rr_fetch #(
  parameter int PTR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic [PTR_W-1:0]       rptr,
  output logic                   mem_req,
  output logic [PTR_W-3:0]       mem_addr,
  input  logic [31:0]            mem_rdata,
  output logic                   done,
  output irq_rr_pkg::iv_entry_t  entry
);
  import irq_rr_pkg::*;

  localparam logic [2:0] LAST = 3'(ENTRY_WORDS);

  logic [2:0] cnt_q, cnt_d;
  logic       cnt_en;
  logic       cap_w0, cap_w1, cap_w2;
  iv_entry_t  entry_q;

  // word counter: 0..3 issue reads, 1..4 take returned data
  always_comb begin
    cnt_en = active || (cnt_q != 3'd0);
    if (!active)            cnt_d = 3'd0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= 3'd0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    mem_req  = active && (cnt_q < LAST);
    mem_addr = {rptr[PTR_W-1:4], cnt_q[1:0]};
    done     = active && (cnt_q == LAST);
    cap_w0   = active && (cnt_q == 3'd1);
    cap_w1   = active && (cnt_q == 3'd2);
    cap_w2   = active && (cnt_q == 3'd3);
  end

  // the fourth word returns at cnt_q == LAST and is not stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
    end else begin
      if (cap_w0) entry_q.src_id   <= mem_rdata[7:0];
      if (cap_w1) entry_q.src_data <= mem_rdata[27:0];
      if (cap_w2) begin
        entry_q.ring_id <= mem_rdata[7:0];
        entry_q.vmid    <= mem_rdata[15:8];
        entry_q.pasid   <= mem_rdata[31:16];
      end
    end
  end

  assign entry = entry_q;

  AST_WORD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R1

endmodule

// File: rtl/irq_ring_reader.sv
module irq_ring_reader #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PTR_W-1:0] wptr_in,
  output logic [PTR_W-1:0] rptr_out,
  output logic             ovf_clr,
  output logic             mem_req,
  output logic [PTR_W-3:0] mem_addr,
  input  logic [31:0]      mem_rdata,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [7:0]       ev_src_id,
  output logic [27:0]      ev_src_data,
  output logic [7:0]       ev_ring_id,
  output logic [7:0]       ev_vmid,
  output logic [15:0]      ev_pasid
);
  import irq_rr_pkg::*;

  localparam logic [PTR_W-1:0] STEP = PTR_W'(ENTRY_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rr_state_e        state_q, state_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [PTR_W-1:0] rpo_q, rpo_d;
  logic             ovfc_q, ovfc_d;
  logic             rptr_en, rpo_en;

  logic [PTR_W-1:0] wptr_eff, jump_ptr, rptr_adv;
  logic             ovf_flag, pending;
  logic             fetch_done;
  iv_entry_t        entry;

  irq_rr_wptr #(.PTR_W(PTR_W)) u_wptr (
    .wptr_in  (wptr_in),
    .rptr     (rptr_q),
    .wptr_eff (wptr_eff),
    .ovf_flag (ovf_flag),
    .jump_ptr (jump_ptr),
    .pending  (pending)
  );

  irq_rr_fetch #(.PTR_W(PTR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (enable && (state_q == ST_FETCH)),
    .rptr      (rptr_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .done      (fetch_done),
    .entry     (entry)
  );

  assign rptr_adv = rptr_q + STEP;

  // next state
  always_comb begin
    state_d = state_q;
    rptr_d  = rptr_q;
    rpo_d   = rpo_q;
    ovfc_d  = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
      rptr_d  = '0;
      rpo_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ovf_flag && !ovfc_q) begin
            rptr_d = jump_ptr;
            ovfc_d = 1'b1;
          end else if (pending) begin
            state_d = ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_done) state_d = ST_EMIT;
        end
        ST_EMIT: begin
          if (ev_ready) begin
            rptr_d  = rptr_adv;
            state_d = (rptr_adv == wptr_eff) ? ST_PUBLISH : ST_FETCH;
          end
        end
        ST_PUBLISH: begin
          rpo_d   = rptr_q;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign rptr_en = (rptr_d != rptr_q);
  assign rpo_en  = (rpo_d != rpo_q);

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      rptr_q  <= '0;
      rpo_q   <= '0;
      ovfc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ovfc_q  <= ovfc_d;
      if (rptr_en) rptr_q <= rptr_d;
      if (rpo_en)  rpo_q  <= rpo_d;
    end
  end

  always_comb begin
    rptr_out    = rpo_q;
    ovf_clr     = ovfc_q;
    ev_valid    = (state_q == ST_EMIT);
    ev_src_id   = entry.src_id;
    ev_src_data = entry.src_data;
    ev_ring_id  = entry.ring_id;
    ev_vmid     = entry.vmid;
    ev_pasid    = entry.pasid;
  end

  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n || !enable)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_src_id) && $stable(ev_src_data)
      && $stable(ev_ring_id) && $stable(ev_vmid) && $stable(ev_pasid))); // R4

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n || !enable)
    (ev_valid && ev_ready) |=> (rptr_q == $past(rptr_q) + STEP)); // R5

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_clr |=> !ovf_clr); // R6

  AST_PUBLISH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_PUBLISH && enable) |=> (rptr_out == $past(rptr_q))); // R8

  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable |=> (rptr_out == '0 && !ev_valid && !mem_req && !ovf_clr)); // R10

endmodule

// File: tb/irq_ring_reader_bench.sv
`timescale 1ns/1ps
module irq_ring_reader_bench;

  localparam int PTR_W = 8;
  localparam int MASK  = (1 << PTR_W) - 1;
  localparam int NWORD = 1 << (PTR_W - 2);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable;
  logic [PTR_W-1:0] wptr_in;
  logic [PTR_W-1:0] rptr_out;
  logic             ovf_clr, mem_req, ev_valid, ev_ready;
  logic [PTR_W-3:0] mem_addr;
  logic [31:0]      mem_rdata;
  logic [7:0]       ev_src_id, ev_ring_id, ev_vmid;
  logic [27:0]      ev_src_data;
  logic [15:0]      ev_pasid;

  always #2.5 clk = ~clk;

  irq_ring_reader #(.PTR_W(PTR_W)) u_irq_ring_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wptr_in(wptr_in),
    .rptr_out(rptr_out), .ovf_clr(ovf_clr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_src_id(ev_src_id), .ev_src_data(ev_src_data),
    .ev_ring_id(ev_ring_id), .ev_vmid(ev_vmid), .ev_pasid(ev_pasid)
  );

  // ring memory with one cycle read latency
  logic [31:0] ring [NWORD];
  always_ff @(posedge clk) if (mem_req) mem_rdata <= ring[mem_addr];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int ready_mode = 0;   // 0 always, 1 random, 2 never

  // behavioural reference: phase 0 idle, 1 fetch, 2 offer, 3 publish
  int m_ph = 0, m_cnt = 0, m_rp = 0, m_rpo = 0, m_ovfc = 0;
  logic [31:0] m_w0 = 0, m_w1 = 0, m_w2 = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_req;
    exp_req = (m_ph == 1) && (m_cnt < 4);
    chk("R1", "mem_req", 32'(mem_req), 32'(exp_req));
    if (exp_req) chk("R1", "mem_addr", 32'(mem_addr), 32'(((m_rp >> 2) + m_cnt) & (NWORD - 1)));
    chk("R4", "ev_valid", 32'(ev_valid), 32'(m_ph == 2));
    if (m_ph == 2) begin
      chk("R2", "src_id",   32'(ev_src_id),   32'(m_w0[7:0]));
      chk("R2", "src_data", 32'(ev_src_data), 32'(m_w1[27:0]));
      chk("R3", "ring_id",  32'(ev_ring_id),  32'(m_w2[7:0]));
      chk("R3", "vmid",     32'(ev_vmid),     32'(m_w2[15:8]));
      chk("R3", "pasid",    32'(ev_pasid),    32'(m_w2[31:16]));
    end
    chk("R6", "ovf_clr", 32'(ovf_clr), 32'(m_ovfc));
    chk("R8", "rptr_out", 32'(rptr_out), 32'(m_rpo));
  endtask

  // advance the model by one clock with the inputs the design will see
  task automatic model_step();
    int eff, nx;
    int ov_n;
    ov_n = 0;
    eff = int'(wptr_in) & MASK & ~1;
    if (!rst_n || !enable) begin
      m_ph = 0; m_cnt = 0; m_rp = 0; m_rpo = 0;
    end else begin
      case (m_ph)
        0: if (wptr_in[0] && m_ovfc == 0) begin
             m_rp = (eff + 16) & MASK; ov_n = 1;
           end else if (eff != m_rp) begin
             m_ph = 1; m_cnt = 0;
           end
        1: begin
             if (m_cnt == 1) m_w0 = ring[(m_rp >> 2) & (NWORD - 1)];
             if (m_cnt == 2) m_w1 = ring[((m_rp >> 2) + 1) & (NWORD - 1)];
             if (m_cnt == 3) m_w2 = ring[((m_rp >> 2) + 2) & (NWORD - 1)];
             if (m_cnt == 4) m_ph = 2; else m_cnt++;
           end
        2: if (ev_ready) begin
             nx = (m_rp + 16) & MASK;
             m_rp = nx;
             m_cnt = 0;
             m_ph = (nx == eff) ? 3 : 1;
           end
        default: begin m_rpo = m_rp; m_ph = 0; end
      endcase
    end
    m_ovfc = ov_n;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      if (ready_mode == 0) ev_ready = 1'b1;
      else if (ready_mode == 2) ev_ready = 1'b0;
      else ev_ready = 1'($urandom % 2);
      // the producer clears its flag once it sees the request
      if (m_ovfc != 0) wptr_in[0] = 1'b0;
      model_step();
      @(negedge clk);
      if (!done) compare();
    end
  endtask

  initial begin
    for (int i = 0; i < NWORD; i++) ring[i] = $urandom;
    rst_n = 1'b0; enable = 1'b0; wptr_in = '0; ev_ready = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11", "rptr_out at reset", 32'(rptr_out), 0);
    chk("R11", "ev_valid at reset", 32'(ev_valid), 0);
    chk("R11", "mem_req at reset",  32'(mem_req), 0);
    chk("R11", "ovf_clr at reset",  32'(ovf_clr), 0);
    tick(3);
    rst_n = 1'b1;
    tick(4);
    enable = 1'b1;
    tick(4);

    // basic drain of three vectors, consumer always ready
    wptr_in = 8'd48;
    tick(40);
    chk("R8", "published after drain", 32'(rptr_out), 48);

    // backpressure, then random ready
    ready_mode = 2; wptr_in = 8'd80;
    tick(15);
    ready_mode = 1;
    tick(80);
    chk("R4", "published after stall", 32'(rptr_out), 80);

    // R5: wrap through the top of the ring
    wptr_in = 8'd32;
    tick(220);
    chk("R5", "published after wrap", 32'(rptr_out), 32);

    // R9: more vectors arrive while draining
    ready_mode = 0; wptr_in = 8'd64;
    tick(8);
    wptr_in = 8'd112;
    tick(80);
    chk("R9", "picked up late arrivals", 32'(rptr_out), 112);

    // R6/R7: overflow flag on bit 0, jump to 176 then a full lap to 160
    wptr_in = 8'd161;
    tick(220);
    chk("R6", "published after overflow", 32'(rptr_out), 160);
    chk("R7", "flag stripped from target", 32'(rptr_out[0]), 0);

    // R10: disable in the middle of a fetch
    wptr_in = 8'd208;
    tick(3);
    enable = 1'b0;
    tick(2);
    chk("R10", "rptr_out cleared", 32'(rptr_out), 0);
    chk("R10", "no request while off", 32'(mem_req), 0);
    enable = 1'b1;
    ready_mode = 1;
    tick(200);
    chk("R10", "restart from slot zero", 32'(rptr_out), 208);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule